// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block measures which of two pulse trains reaches its rising edge first. Input `sig_a` is an external signal. Input `sig_b` is an internal reference. Both are sampled by a fast system clock. Each input passes through a short synchronizer and a registered rising-edge detector. The detected edges then drive a three-state tracking machine.

While A leads, the machine drives a correction of logic 1. While B leads, it drives logic 0. In all other cases the output is released, which models a disconnected pin. The pin is modelled as a data bit, `corr_data`, together with an enable bit, `corr_oe`. Only the position of each rising edge matters: the duty cycle of either input has no effect.

A lock flag, `lock_det`, is high whenever no correction is being driven. In a phase-locked loop this flag stays high once the two inputs agree in both frequency and phase.

Top module: `pfc_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to the released state: `corr_oe`=0, `corr_data`=0 and `lock_det`=1.
- R2: From the released state, a rising edge on A alone moves the block to the up-drive state: `corr_oe`=1 and `corr_data`=1.
- R3: From the released state, a rising edge on B alone moves the block to the down-drive state: `corr_oe`=1 and `corr_data`=0.
- R4: In the up-drive state, a rising edge on B alone releases the output. In the down-drive state, a rising edge on A alone releases the output.
- R5: A further rising edge on the input that is already leading keeps the current drive state.
- R6: When rising edges of A and B are detected in the same clock cycle, the block ends that cycle in the released state, whatever state it was in.
- R7: Falling edges and the length of high or low levels never change the outputs. With no rising edge detected, the state holds.
- R8: `lock_det` is 1 exactly when `corr_oe` is 0.
- R9: A rising edge of an input set up before clock edge 1 changes the outputs after clock edge 4, and not before. The pipeline is two synchronizer flops, the edge register and the state register.
- R10: When A produces several rising edges per rising edge of B, the output is only ever driven high or released, never driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_a | input | 1 | External pulse input A |
| sig_b | input | 1 | Reference pulse input B |
| corr_data | output | 1 | Correction level, meaningful only while `corr_oe` is 1 |
| corr_oe | output | 1 | Correction drive enable; 0 models the high-impedance condition |
| lock_det | output | 1 | Lock indicator, high while no correction is driven |

## Verification
The assertions assume that `sig_a` and `sig_b` are held low through reset, so that reset release does not itself look like a rising edge. They also assume every level on either input is held for at least one clock, so the edge register sees each transition. The stimulus holds both inputs low during reset. It changes the inputs only on falling clock edges and holds each new level for several cycles before the outputs are compared with the bench's own edge-driven state model. Random level patterns are mixed with directed cases for the corner cases: simultaneous edges, repeated leading edges, falling edges only, and A running faster than B.

// File: rtl/pfc_pkg.sv
// Package: shared types for the phase-frequency comparator.
// Assumes: nothing beyond IEEE 1800-2017.
package pfc_pkg;
    // Drive state of the comparator output.
    typedef enum logic [1:0] {
        ST_RELEASED = 2'b00,
        ST_UP       = 2'b01,
        ST_DOWN     = 2'b10
    } pfc_state_t;

    // Number of comparator inputs handled by the edge front end.
    localparam int unsigned PFC_NUM_INPUTS = 2;
endpackage

// File: rtl/pfc_edge_sense.sv
// Module: pfc_edge_sense
// Brings one asynchronous pulse input into the clock domain through a
// SYNC_STAGES-deep flop chain, then registers a one-cycle pulse for each
// rising edge seen on the synchronized level.
// Assumes: the input is low while rst_n is low.
module pfc_edge_sense #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_q
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_r;
    logic          prev_r;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_r <= '0;
        else        sync_r <= {sync_r[LAST-1:0], din};
    end

    // Remember the synchronized level and register the rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_r <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            prev_r <= sync_r[LAST];
            rise_q <= sync_r[LAST] & ~prev_r;
        end
    end

    // An edge pulse lasts one cycle only (R7: levels produce no repeat pulses).
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |=> !rise_q);
endmodule

// File: rtl/pfc_state_core.sv
// Module: pfc_state_core
// Three-state tracker. It records which input's rising edge arrived first
// and releases the output when the other input's rising edge follows.
// Assumes: rise_a and rise_b are one-cycle pulses from the edge front end.
module pfc_state_core
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_a,
    input  logic       rise_b,
    output pfc_state_t state_q
);
    pfc_state_t state_d;

    // Next-state selection from the detected edges.
    always_comb begin
        state_d = state_q;
        if (rise_a && rise_b) begin
            state_d = ST_RELEASED;
        end else begin
            unique case (state_q)
                ST_RELEASED: begin
                    if (rise_a)      state_d = ST_UP;
                    else if (rise_b) state_d = ST_DOWN;
                end
                ST_UP:   if (rise_b) state_d = ST_RELEASED;
                ST_DOWN: if (rise_a) state_d = ST_RELEASED;
                default: state_d = ST_RELEASED;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RELEASED;
        else        state_q <= state_d;
    end

    assert_a_starts_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASED && rise_a && !rise_b) |=> state_q == ST_UP);
    assert_b_starts_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASED && rise_b && !rise_a) |=> state_q == ST_DOWN);
    assert_up_ends_on_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && rise_b && !rise_a) |=> state_q == ST_RELEASED);
    assert_down_ends_on_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && rise_a && !rise_b) |=> state_q == ST_RELEASED);
    assert_lead_repeat_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && rise_a && !rise_b) |=> state_q == ST_UP);
    assert_both_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_a && rise_b) |=> state_q == ST_RELEASED);
    assert_no_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_a && !rise_b) |=> $stable(state_q));
endmodule

// File: rtl/pfc_top.sv
// Module: pfc_top
// Phase-frequency comparator. Two edge front ends feed the state tracker.
// The tracker state is decoded into a drive-enable and data pair that
// models a three-state pin, plus a lock flag.
// Assumes: sig_a and sig_b are low during reset; every level lasts at least one clock.
module pfc_top
    import pfc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_a,
    input  logic sig_b,
    output logic corr_data,
    output logic corr_oe,
    output logic lock_det
);
    logic [PFC_NUM_INPUTS-1:0] raw_in;
    logic [PFC_NUM_INPUTS-1:0] rise_v;
    pfc_state_t                state_q;

    assign raw_in = {sig_b, sig_a};

    // One edge front end per comparator input.
    for (genvar gi = 0; gi < PFC_NUM_INPUTS; gi++) begin : g_edge
        pfc_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (raw_in[gi]),
            .rise_q (rise_v[gi])
        );
    end

    pfc_state_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_a  (rise_v[0]),
        .rise_b  (rise_v[1]),
        .state_q (state_q)
    );

    // Decode the tracker state into pin drive and lock indication.
    always_comb begin
        corr_oe   = (state_q != ST_RELEASED);
        corr_data = (state_q == ST_UP);
        lock_det  = (state_q == ST_RELEASED);
    end

    assert_lock_is_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_det != corr_oe);
    assert_released_data_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_oe |-> !corr_data);
endmodule

// File: tb/pfc_top_bench.sv
// Bench for pfc_top: directed corner cases plus seeded random levels,
// compared with an edge-driven reference model.
module pfc_top_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic sig_a;
    logic sig_b;
    logic corr_data;
    logic corr_oe;
    logic lock_det;

    int checks = 0;
    int fails  = 0;
    int exp_st = 0;   // 0 released, 1 up, 2 down
    bit done   = 0;

    always #2 clk = ~clk;

    pfc_top u_pfc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_a     (sig_a),
        .sig_b     (sig_b),
        .corr_data (corr_data),
        .corr_oe   (corr_oe),
        .lock_det  (lock_det)
    );

    // Reference state update from the detected rising edges.
    function automatic int next_st(int s, bit ra, bit rb);
        if (ra && rb) return 0;
        case (s)
            0: return ra ? 1 : (rb ? 2 : 0);
            1: return rb ? 0 : 1;
            2: return ra ? 0 : 2;
            default: return 0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Compare every output with the model state; also check lock (R8).
    task automatic check_outs(string req);
        int act;
        int expv;
        act  = {lock_det, corr_oe, corr_data};
        expv = {exp_st == 0, exp_st != 0, exp_st == 1};
        check(act == expv, req, act, expv);
        check(lock_det == !corr_oe, "R8", lock_det, !corr_oe);
    endtask

    // Apply new levels on a falling edge, update the model, settle, compare.
    task automatic step(bit na, bit nb, string req);
        bit ra;
        bit rb;
        ra = na & ~sig_a;
        rb = nb & ~sig_b;
        @(negedge clk);
        sig_a = na;
        sig_b = nb;
        exp_st = next_st(exp_st, ra, rb);
        repeat (6) @(negedge clk);
        check_outs(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0451);
        rst_n = 1'b0;
        sig_a = 1'b0;
        sig_b = 1'b0;
        repeat (4) @(negedge clk);
        exp_st = 0;
        check_outs("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        step(1, 0, "R2 A first");
        step(0, 0, "R7 falling A");
        step(1, 0, "R5 repeat A");
        step(1, 1, "R4 B ends up");
        step(0, 0, "R7 both fall");
        step(0, 1, "R3 B first");
        step(0, 0, "R7 falling B");
        step(0, 1, "R5 repeat B");
        step(1, 0, "R4 A ends down");
        step(0, 0, "R7 idle");
        step(0, 1, "R3 down again");
        step(1, 0, "R4 release");
        step(0, 0, "R7 idle");
        step(1, 0, "R2 up again");
        step(0, 0, "R7 hold up");
        step(1, 1, "R6 both from up");
        step(0, 0, "R7 both fall");
        step(0, 1, "R3 down for R6");
        step(0, 0, "R7 fall");
        step(1, 1, "R6 both from down");
        step(0, 0, "R7 settle");

        // R9 latency: new output only after the fourth rising clock edge.
        @(negedge clk);
        sig_a = 1'b1;
        repeat (3) @(negedge clk);
        check(corr_oe == 1'b0, "R9 too early", corr_oe, 0);
        @(negedge clk);
        check(corr_oe == 1'b1 && corr_data == 1'b1, "R9 on time",
              {corr_oe, corr_data}, 3);
        exp_st = 1;
        step(0, 0, "R7 after R9");
        step(0, 1, "R4 after R9");
        step(0, 0, "R7 settle");

        // R10: A runs three times faster than B.
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 3; j++) begin
                step(1, 0, "R10 A pulse");
                check(!corr_oe || corr_data, "R10 never low", corr_data, 1);
                step(0, 0, "R10 A low");
            end
            step(0, 1, "R10 B pulse");
            check(!corr_oe || corr_data, "R10 never low", corr_data, 1);
            step(0, 0, "R10 B low");
        end

        // Random level patterns checked against the model.
        for (int n = 0; n < 300; n++) begin
            bit ra_lvl;
            bit rb_lvl;
            ra_lvl = 1'($urandom());
            rb_lvl = 1'($urandom());
            step(ra_lvl, rb_lvl, "R2 R3 R4 R6 R7 random");
        end

        // Reset in the middle of a drive state.
        step(0, 0, "R7 pre-reset");
        step(1, 0, "R2 pre-reset");
        @(negedge clk);
        sig_a = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_st = 0;
        check_outs("R1 mid reset");
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule